// File: doc/BRIEF.md
# Cached Configuration Register Bank with Dirty-Entry Flush

This block keeps a local image of the configuration registers of an external device that is programmed over a slow serial link. Software-facing logic updates registers in the local image and reads them back without touching the link. Each register carries a flag that records whether the image has moved ahead of the device. A single commit strobe flushes only those registers, lowest address first. For every one it raises a write request toward a serial master and waits for that master's acknowledge before it moves on.

A second kind of write updates the image and pushes the word to the device at once, which leaves the register clean. One address is never cached. It names a status word that lives in the device, so a read of it always becomes a device read. While a commit, a pushed write or a device read is in flight, the block raises a busy signal. A requester keeps its request asserted until busy falls.

Top module: `cfg_shadow_bank`

## Requirements
- R1: The bank holds 31 registers of 16 bits at addresses 0 to 30. After reset, register i holds the low 16 bits of (i * 0x9E37) XOR 0x5A3C. host_busy, rd_valid, commit_done, dev_wr_req and dev_rd_req are all low.
- R2: Reset marks all 31 registers dirty, so the first commit writes every register to the device with its reset word.
- R3: A commit sends device writes only for dirty registers, in ascending address order. Only one request is outstanding at a time. Address and data stay stable until dev_wr_ack.
- R4: A register is clean once the device has acknowledged its write. A commit with nothing dirty issues no device write and still pulses commit_done.
- R5: A field write (host_op = 0) to an address below 31 replaces the cached word and marks the register dirty. It causes no device traffic.
- R6: A direct write (host_op = 1) to an address below 31 replaces the cached word and issues one device write of that word right away. The register is left clean, so the next commit does not resend it.
- R7: A read (host_op = 2) of an address below 31 returns the cached word with rd_valid in the cycle after acceptance. It causes no device traffic.
- R8: A read of address 31 raises dev_rd_req with dev_rd_addr = 31. It returns dev_rd_data, as captured at dev_rd_ack, with rd_valid.
- R9: A field or direct write to address 31 is dropped: no device write follows and no register becomes dirty. host_op = 3 does nothing.
- R10: host_busy is high from the commit strobe until the scan ends. commit_done is a single-cycle pulse, and busy is low in that cycle. A request held during busy is accepted only afterwards, so a field write held during a commit is not part of that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit | input | 1 | Strobe that starts a flush of dirty registers |
| host_req | input | 1 | Host request, held until accepted while host_busy is low |
| host_op | input | 2 | 0 field write, 1 direct write, 2 read, 3 no-op |
| host_addr | input | 5 | Register address, 31 is the device status word |
| host_wdata | input | 16 | Write data |
| host_busy | output | 1 | Block cannot accept a request this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read result |
| commit_done | output | 1 | Pulse when a flush has finished |
| dev_wr_req | output | 1 | Write request to serial master |
| dev_wr_addr | output | 5 | Address of the write request |
| dev_wr_data | output | 16 | Data of the write request |
| dev_wr_ack | input | 1 | Serial master finished the write |
| dev_rd_req | output | 1 | Read request to serial master |
| dev_rd_addr | output | 5 | Address of the read request |
| dev_rd_data | input | 16 | Word read from the device |
| dev_rd_ack | input | 1 | Serial master finished the read, dev_rd_data valid |

## Verification
The bench builds the bank with its default 31 registers of 16 bits. With these values the 5-bit address reaches exactly one slot past the array, the uncached status address, so random addresses regularly hit the readback path and the dropped writes to it. Thirty-one dirty flags keep the full first flush and the randomly mixed partial flushes short enough to compare entry by entry against the bench's own ordered list. The serial master model acknowledges after a random delay, which exercises the request-hold rule.

// File: rtl/cfgsh_pkg.sv
package cfgsh_pkg;

  typedef enum logic [1:0] {
    OP_FIELD  = 2'd0,
    OP_DIRECT = 2'd1,
    OP_READ   = 2'd2,
    OP_NONE   = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DEVRD = 2'd3
  } seq_state_e;

  // reset image word for register idx (wide result, callers truncate)
  function automatic logic [31:0] reset_word(input int unsigned idx);
    logic [31:0] prod;
    prod = 32'(idx) * 32'h0000_9E37;
    return prod ^ 32'h0000_5A3C;
  endfunction

endpackage

// File: rtl/cfgsh_store.sv
module cfgsh_store
  import cfgsh_pkg::*;
#(
  parameter int NREG = 31,
  parameter int DW   = 16,
  parameter int AW   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_en,
  input  logic [AW-1:0]            upd_idx,
  input  logic [DW-1:0]            upd_data,
  input  logic                     upd_mark,
  input  logic                     clr_en,
  input  logic [AW-1:0]            clr_idx,
  output logic [NREG-1:0][DW-1:0]  words,
  output logic [NREG-1:0]          dirty
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic hit_upd;
    logic hit_clr;
    assign hit_upd = upd_en && (upd_idx == AW'(g));
    assign hit_clr = clr_en && (clr_idx == AW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= DW'(reset_word(g));
        dirty[g] <= 1'b1;
      end else begin
        if (hit_upd) words[g] <= upd_data;
        if (hit_upd && upd_mark) dirty[g] <= 1'b1;
        else if (hit_clr)        dirty[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfgsh_seq.sv
module cfgsh_seq
  import cfgsh_pkg::*;
#(
  parameter int NREG = 31,
  parameter int AW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             host_req_i,
  input  host_op_e         host_op_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [NREG-1:0]  dirty_i,
  input  logic             dev_wr_ack_i,
  input  logic             dev_rd_ack_i,
  output logic             busy_o,
  output logic             dev_wr_req_o,
  output logic             dev_rd_req_o,
  output logic [AW-1:0]    cur_idx_o,
  output logic             upd_en_o,
  output logic             upd_mark_o,
  output logic             clr_en_o,
  output logic             cache_rd_o,
  output logic             dev_rd_done_o,
  output logic             commit_done_o,
  output logic             in_commit_o
);

  localparam logic [AW-1:0] RB_ADDR = AW'(NREG);

  // lowest set index of the dirty vector
  function automatic logic [AW-1:0] first_dirty(input logic [NREG-1:0] v);
    logic [AW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (v[i]) r = AW'(i);
    end
    return r;
  endfunction

  seq_state_e    state;
  logic [AW-1:0] cur_idx;
  logic          direct_q;
  logic          done_q;

  logic accept;
  logic addr_in_bank;
  logic is_wr_op;
  logic start_direct;
  logic start_devrd;
  logic any_dirty;

  assign accept       = (state == ST_IDLE) && !commit_i && host_req_i;
  assign addr_in_bank = host_addr_i < RB_ADDR;
  assign is_wr_op     = (host_op_i == OP_FIELD) || (host_op_i == OP_DIRECT);
  assign upd_en_o     = accept && addr_in_bank && is_wr_op;
  assign upd_mark_o   = (host_op_i == OP_FIELD);
  assign start_direct = upd_en_o && (host_op_i == OP_DIRECT);
  assign start_devrd  = accept && (host_op_i == OP_READ) && (host_addr_i == RB_ADDR);
  assign cache_rd_o   = accept && (host_op_i == OP_READ) && (host_addr_i != RB_ADDR);
  assign any_dirty    = |dirty_i;

  assign busy_o        = (state != ST_IDLE) || commit_i;
  assign dev_wr_req_o  = (state == ST_WRITE);
  assign dev_rd_req_o  = (state == ST_DEVRD);
  assign clr_en_o      = (state == ST_WRITE) && dev_wr_ack_i;
  assign dev_rd_done_o = (state == ST_DEVRD) && dev_rd_ack_i;
  assign in_commit_o   = (state == ST_SCAN) || ((state == ST_WRITE) && !direct_q);
  assign cur_idx_o     = cur_idx;
  assign commit_done_o = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_idx  <= '0;
      direct_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (commit_i) begin
            state    <= ST_SCAN;
            direct_q <= 1'b0;
          end else if (start_direct) begin
            state    <= ST_WRITE;
            cur_idx  <= host_addr_i;
            direct_q <= 1'b1;
          end else if (start_devrd) begin
            state <= ST_DEVRD;
          end
        end
        ST_SCAN: begin
          if (any_dirty) begin
            cur_idx <= first_dirty(dirty_i);
            state   <= ST_WRITE;
          end else begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          if (dev_wr_ack_i) state <= direct_q ? ST_IDLE : ST_SCAN;
        end
        ST_DEVRD: begin
          if (dev_rd_ack_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
  import cfgsh_pkg::*;
#(
  parameter int NREG = 31,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          host_req,
  input  logic [1:0]    host_op,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          commit_done,
  output logic          dev_wr_req,
  output logic [AW-1:0] dev_wr_addr,
  output logic [DW-1:0] dev_wr_data,
  input  logic          dev_wr_ack,
  output logic          dev_rd_req,
  output logic [AW-1:0] dev_rd_addr,
  input  logic [DW-1:0] dev_rd_data,
  input  logic          dev_rd_ack
);

  logic [NREG-1:0][DW-1:0] words;
  logic [NREG-1:0]         dirty_vec;
  logic [AW-1:0]           cur_idx;
  logic                    upd_en;
  logic                    upd_mark;
  logic                    clr_en;
  logic                    cache_rd;
  logic                    dev_rd_done;
  logic                    in_commit;
  logic [DW-1:0]           cached_word;
  logic [DW-1:0]           cur_word;

  cfgsh_seq #(.NREG(NREG), .AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_i      (commit),
    .host_req_i    (host_req),
    .host_op_i     (host_op_e'(host_op)),
    .host_addr_i   (host_addr),
    .dirty_i       (dirty_vec),
    .dev_wr_ack_i  (dev_wr_ack),
    .dev_rd_ack_i  (dev_rd_ack),
    .busy_o        (host_busy),
    .dev_wr_req_o  (dev_wr_req),
    .dev_rd_req_o  (dev_rd_req),
    .cur_idx_o     (cur_idx),
    .upd_en_o      (upd_en),
    .upd_mark_o    (upd_mark),
    .clr_en_o      (clr_en),
    .cache_rd_o    (cache_rd),
    .dev_rd_done_o (dev_rd_done),
    .commit_done_o (commit_done),
    .in_commit_o   (in_commit)
  );

  cfgsh_store #(.NREG(NREG), .DW(DW), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_idx  (host_addr),
    .upd_data (host_wdata),
    .upd_mark (upd_mark),
    .clr_en   (clr_en),
    .clr_idx  (cur_idx),
    .words    (words),
    .dirty    (dirty_vec)
  );

  assign cached_word = (host_addr < AW'(NREG)) ? words[host_addr] : '0;
  assign cur_word    = (cur_idx < AW'(NREG)) ? words[cur_idx] : '0;
  assign dev_wr_addr = cur_idx;
  assign dev_wr_data = cur_word;
  assign dev_rd_addr = AW'(NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cache_rd || dev_rd_done;
      if (cache_rd)         rd_data <= cached_word;
      else if (dev_rd_done) rd_data <= dev_rd_data;
    end
  end

endmodule

// File: rtl/cfgsh_checker.sv
module cfgsh_checker #(
  parameter int NREG = 31,
  parameter int DW   = 16,
  localparam int AW  = $clog2(NREG + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dev_wr_req,
  input logic            dev_wr_ack,
  input logic [AW-1:0]   dev_wr_addr,
  input logic [DW-1:0]   dev_wr_data,
  input logic            dev_rd_req,
  input logic [AW-1:0]   dev_rd_addr,
  input logic            host_busy,
  input logic            commit_done,
  input logic            in_commit,
  input logic [NREG-1:0] dirty_vec
);

  logic [AW-1:0] last_q;
  logic          have_q;
  logic          ack_seen_q;
  logic [AW-1:0] ack_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= '0;
      have_q     <= 1'b0;
      ack_seen_q <= 1'b0;
      ack_addr_q <= '0;
    end else begin
      ack_seen_q <= dev_wr_req && dev_wr_ack;
      ack_addr_q <= dev_wr_addr;
      if (!in_commit) begin
        have_q <= 1'b0;
      end else if (dev_wr_req && dev_wr_ack) begin
        have_q <= 1'b1;
        last_q <= dev_wr_addr;
      end
    end
  end

  p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_wr_req && dev_rd_req));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_req && !dev_wr_ack) |=>
      (dev_wr_req && $stable(dev_wr_addr) && $stable(dev_wr_data)));

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_commit && dev_wr_req && have_q) |-> (dev_wr_addr > last_q));

  p_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_seen_q |-> !dirty_vec[ack_addr_q]);

  p_rb_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd_req |-> (dev_rd_addr == AW'(NREG)));

  p_no_rb_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_req |-> (dev_wr_addr < AW'(NREG)));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr_req || dev_rd_req) |-> host_busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done |=> !commit_done);

endmodule

bind cfg_shadow_bank cfgsh_checker #(.NREG(NREG), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_wr_req  (dev_wr_req),
  .dev_wr_ack  (dev_wr_ack),
  .dev_wr_addr (dev_wr_addr),
  .dev_wr_data (dev_wr_data),
  .dev_rd_req  (dev_rd_req),
  .dev_rd_addr (dev_rd_addr),
  .host_busy   (host_busy),
  .commit_done (commit_done),
  .in_commit   (in_commit),
  .dirty_vec   (dirty_vec)
);

// File: tb/cfg_shadow_bank_test.sv
module cfg_shadow_bank_test;

  localparam int NREG = 31;
  localparam int DW   = 16;
  localparam int AW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          commit = 1'b0;
  logic          host_req = 1'b0;
  logic [1:0]    host_op = 2'd3;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_busy;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          commit_done;
  logic          dev_wr_req;
  logic [AW-1:0] dev_wr_addr;
  logic [DW-1:0] dev_wr_data;
  logic          dev_wr_ack = 1'b0;
  logic          dev_rd_req;
  logic [AW-1:0] dev_rd_addr;
  logic [DW-1:0] dev_rd_data = '0;
  logic          dev_rd_ack = 1'b0;

  cfg_shadow_bank #(.NREG(NREG), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .commit(commit), .host_req(host_req),
    .host_op(host_op), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_busy(host_busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .commit_done(commit_done), .dev_wr_req(dev_wr_req),
    .dev_wr_addr(dev_wr_addr), .dev_wr_data(dev_wr_data),
    .dev_wr_ack(dev_wr_ack), .dev_rd_req(dev_rd_req),
    .dev_rd_addr(dev_rd_addr), .dev_rd_data(dev_rd_data),
    .dev_rd_ack(dev_rd_ack)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic [DW-1:0]   exp_val [NREG];
  logic [NREG-1:0] exp_dirty;

  // serial master log
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int            log_n  = 0;
  int            rd_cnt = 0;
  int            wdly   = 1;
  int            rdly   = 2;
  logic [DW-1:0] rb_word = 16'h1234;

  function automatic logic [DW-1:0] start_word(input int i);
    int unsigned v;
    v = (32'(i) * 32'd40503) ^ 32'd23100;
    return DW'(v & 32'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // serial master model: acks after a random delay
  always @(negedge clk) begin
    dev_wr_ack = 1'b0;
    dev_rd_ack = 1'b0;
    if (dev_wr_req) begin
      if (wdly == 0) begin
        if (log_n < 64) begin
          log_addr[log_n] = dev_wr_addr;
          log_data[log_n] = dev_wr_data;
        end
        log_n++;
        dev_wr_ack = 1'b1;
        wdly = int'($urandom % 4);
      end else begin
        wdly--;
      end
    end
    if (dev_rd_req) begin
      if (rdly == 0) begin
        rd_cnt++;
        dev_rd_data = rb_word;
        dev_rd_ack  = 1'b1;
        rdly = int'($urandom % 4);
      end else begin
        rdly--;
      end
    end
  end

  task automatic wait_idle();
    int n = 0;
    while (host_busy && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic host_do(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
    host_req   = 1'b1;
    host_op    = op;
    host_addr  = a;
    host_wdata = d;
    wait_idle();
    @(negedge clk);
    host_req = 1'b0;
    host_op  = 2'd3;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] got);
    int n = 0;
    host_do(2'd2, a, '0);
    while (!rd_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    got = rd_data;
    chk(rd_valid, "R7/R8 rd_valid", 32'(rd_valid), 32'd1);
    wait_idle();
  endtask

  task automatic check_flush(input string tag);
    int j = 0;
    int want = $countones(exp_dirty);
    chk(log_n == want, {tag, " R3 write count"}, 32'(log_n), 32'(want));
    for (int i = 0; i < NREG; i++) begin
      if (exp_dirty[i] && j < 64 && j < log_n) begin
        chk(log_addr[j] == AW'(i), {tag, " R3 order"}, 32'(log_addr[j]), 32'(i));
        chk(log_data[j] == exp_val[i], {tag, " R3 data"}, 32'(log_data[j]),
            32'(exp_val[i]));
        j++;
      end
    end
    exp_dirty = '0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!commit_done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(commit_done, "R10 done pulse seen", 32'(commit_done), 32'd1);
    chk(!host_busy, "R10 busy low at done", 32'(host_busy), 32'd0);
  endtask

  task automatic do_commit(input string tag);
    log_n  = 0;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    chk(host_busy, "R10 busy during commit", 32'(host_busy), 32'd1);
    wait_done();
    check_flush(tag);
    @(negedge clk);
    chk(!commit_done, "R10 done one cycle", 32'(commit_done), 32'd0);
  endtask

  task automatic do_field(input logic [AW-1:0] a, input logic [DW-1:0] d);
    log_n = 0;
    host_do(2'd0, a, d);
    repeat (3) @(negedge clk);
    chk(log_n == 0, "R5/R9 no device write on field write", 32'(log_n), 32'd0);
    if (a < AW'(NREG)) begin
      exp_val[a]   = d;
      exp_dirty[a] = 1'b1;
    end
  endtask

  task automatic do_direct(input logic [AW-1:0] a, input logic [DW-1:0] d);
    log_n = 0;
    host_do(2'd1, a, d);
    wait_idle();
    repeat (2) @(negedge clk);
    if (a < AW'(NREG)) begin
      chk(log_n == 1, "R6 one device write", 32'(log_n), 32'd1);
      chk(log_addr[0] == a && log_data[0] == d, "R6 write content",
          {11'd0, log_addr[0], log_data[0]}, {11'd0, a, d});
      exp_val[a]   = d;
      exp_dirty[a] = 1'b0;
    end else begin
      chk(log_n == 0, "R9 write to readback dropped", 32'(log_n), 32'd0);
    end
  endtask

  task automatic do_check_read(input logic [AW-1:0] a);
    logic [DW-1:0] got;
    int rc0;
    rc0 = rd_cnt;
    rb_word = DW'($urandom);
    do_read(a, got);
    if (a == AW'(NREG)) begin
      chk(got == rb_word, "R8 readback data", 32'(got), 32'(rb_word));
      chk(rd_cnt == rc0 + 1, "R8 device read issued", 32'(rd_cnt), 32'(rc0 + 1));
    end else begin
      chk(got == exp_val[a], "R7 cached data", 32'(got), 32'(exp_val[a]));
      chk(rd_cnt == rc0, "R7 no device read", 32'(rd_cnt), 32'(rc0));
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) exp_val[i] = start_word(i);
    exp_dirty = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!host_busy && !rd_valid && !commit_done && !dev_wr_req && !dev_rd_req,
        "R1 idle outputs", {27'd0, host_busy, rd_valid, commit_done, dev_wr_req,
        dev_rd_req}, 32'd0);
    do_check_read(5'd0);
    do_check_read(5'd30);

    // R2 first commit writes everything
    do_commit("R2 first flush");

    // R4 nothing dirty
    do_commit("R4 empty flush");

    // R5 field writes then flush of just those
    do_field(5'd7, 16'hA001);
    do_field(5'd2, 16'hA002);
    do_field(5'd29, 16'hA003);
    do_check_read(5'd7);
    do_commit("R3 partial flush");

    // R6 direct write, then commit resends nothing
    do_field(5'd4, 16'hB001);
    do_direct(5'd4, 16'hB002);
    do_commit("R6 after direct");

    // R9 writes to readback address are dropped
    do_field(5'd31, 16'hC001);
    do_direct(5'd31, 16'hC002);
    do_commit("R9 after dropped writes");

    // R8 readback
    do_check_read(5'd31);

    // R10 field write held while a commit runs
    do_field(5'd5, 16'hD005);
    log_n      = 0;
    commit     = 1'b1;
    host_req   = 1'b1;
    host_op    = 2'd0;
    host_addr  = 5'd3;
    host_wdata = 16'hBEEF;
    @(negedge clk);
    commit = 1'b0;
    chk(host_busy, "R10 busy holds request", 32'(host_busy), 32'd1);
    wait_done();
    check_flush("R10 held write excluded");
    @(negedge clk);
    host_req = 1'b0;
    host_op  = 2'd3;
    exp_val[3]   = 16'hBEEF;
    exp_dirty[3] = 1'b1;
    do_check_read(5'd3);
    do_commit("R10 held write flushed");

    // random mix
    for (int k = 0; k < 150; k++) begin
      int sel;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      sel = int'($urandom % 4);
      a   = AW'($urandom);
      d   = DW'($urandom);
      case (sel)
        0: do_field(a, d);
        1: do_direct(a, d);
        2: do_check_read(a);
        default: do_commit("R3 random flush");
      endcase
    end
    do_commit("R3 final flush");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule